// File: doc/BRIEF.md
# AGP Request Dispatcher

This block sits behind the target side of a graphics port and turns each incoming request into work for the memory side. A request arrives with a 4-bit command code, an address, a length, byte enables and a flag that says whether the address decodes to the hub side rather than to DRAM. The block decodes the command and places the request in one of two queues, one for normal priority and one for high priority. A single issue stage then drains the queues toward a DRAM-side request port, and the high-priority queue always goes first.

Some requests never reach memory. Flushes and reads aimed at the hub side are answered inside the block with a fixed 64-bit filler pattern. Writes aimed at the hub side still go to DRAM, but with every byte enable cleared, so memory does not change. A fence takes one slot in the normal queue, issues nothing and returns nothing. Reserved codes are accepted and then dropped. Read data from the memory side is passed back to the initiator as completion beats. The block adds no coherency action: every memory request it emits is non-snooped.

The memory side returns one data beat for each read, with the class of that read, and must not return data for a class that has no read outstanding. The memory side has no backpressure on its read-data path.

Top module: `agp_req_dispatch`

## Requirements
- R1: After reset, with no request presented, mem_valid and cpl_valid are low and req_ready is high.
- R2: Codes 0000 and 1000 issue a normal-priority memory read. Codes 0001 and 1001 issue a high-priority memory read. Code 0100 issues a normal-priority memory write and code 0101 issues a high-priority memory write. On the request, mem_write is 1 for writes and 0 for reads, and mem_hipri is 1 for high priority. Address and length pass through unchanged. Reads carry mem_be = 8'hFF and writes carry the request's byte enables.
- R3: Codes 0010, 0011, 0110, 0111, 1011, 1101, 1110 and 1111 are always accepted (req_ready = 1). They produce neither a memory request nor a completion.
- R4: A flush (code 1010) produces no memory request. It returns exactly one completion beat with cpl_data = FILL_PAT and cpl_hipri = 0.
- R5: A read code with req_to_hub = 1 produces no memory request. It returns one completion beat with cpl_data = FILL_PAT, in the read's own priority class.
- R6: A write code with req_to_hub = 1 issues a memory write of its class with mem_be = 0.
- R7: A fence (code 1100) takes one normal-queue slot. It issues no memory request and returns no completion, and it retires in the one cycle it spends at the head. Normal requests accepted after it issue only after it retires.
- R8: Unless a request is being held (R11), the head of the high-priority queue is served before the head of the normal queue.
- R9: req_ready is low exactly when the code presented is non-reserved and the queue of its class holds DEPTH entries. Every accepted request is served exactly once.
- R10: Read data accepted on mem_rvalid appears on cpl_valid/cpl_data one cycle later, with cpl_hipri equal to mem_rhipri. A memory read is not issued while OUT_MAX reads of its class are outstanding. A local completion is produced only when its class has no read outstanding and no read data arrives in that cycle. As a result, completions within a class follow issue order.
- R11: Once mem_valid is high without mem_ready, it stays high in the next cycle with the same write flag, class, address, length and byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 4 | Command code |
| req_to_hub | input | 1 | Request target decodes to the hub side |
| req_addr | input | AW | Request address |
| req_len | input | LW | Request length |
| req_be | input | 8 | Byte enables for writes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory side takes the request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_hipri | output | 1 | Request belongs to the high-priority class |
| mem_addr | output | AW | Memory address |
| mem_len | output | LW | Memory length |
| mem_be | output | 8 | Memory byte enables |
| mem_rvalid | input | 1 | Read data beat returned |
| mem_rhipri | input | 1 | Class of the returned read |
| mem_rdata | input | 64 | Returned read data |
| cpl_valid | output | 1 | Completion beat to the initiator |
| cpl_hipri | output | 1 | Class of the completion |
| cpl_data | output | 64 | Completion data |

## Verification
The bench builds the dispatcher with DEPTH = 4, OUT_MAX = 3, AW = 16 and LW = 4. Shallow queues fill after only a few requests while the memory side stalls, so the ready drop in both classes and the refusal at a full queue are reached quickly. A limit of three outstanding reads makes the read-issue stall, and the wait that local completions impose behind earlier reads, common in the random traffic. The narrow address keeps the returned data distinct from the filler pattern.

// File: rtl/agp_disp_pkg.sv
// Shared types and command decoding for the request dispatcher.
// Assumes a 4-bit command code and quadword (64-bit) completion beats.
package agp_disp_pkg;

    localparam int QW  = 64;
    localparam int BEW = 8;

    // What a queued entry asks the issue stage to do
    typedef enum logic [1:0] {
        KD_RD    = 2'd0,
        KD_WR    = 2'd1,
        KD_LOC   = 2'd2,
        KD_FENCE = 2'd3
    } kind_e;

    typedef struct packed {
        logic  ok;     // code is not reserved
        logic  hi;     // high-priority class
        kind_e kind;
    } dec_t;

    // Map a command code and target side onto class and kind
    function automatic dec_t decode_cmd(input logic [3:0] cmd, input logic to_hub);
        dec_t d;
        d.ok   = 1'b1;
        d.hi   = 1'b0;
        d.kind = KD_RD;
        case (cmd)
            4'b0000, 4'b1000: d.kind = KD_RD;
            4'b0001, 4'b1001: begin d.hi = 1'b1; d.kind = KD_RD; end
            4'b0100:          d.kind = KD_WR;
            4'b0101:          begin d.hi = 1'b1; d.kind = KD_WR; end
            4'b1010:          d.kind = KD_LOC;
            4'b1100:          d.kind = KD_FENCE;
            default:          d.ok = 1'b0;
        endcase
        if (d.ok && to_hub && d.kind == KD_RD)
            d.kind = KD_LOC;
        return d;
    endfunction

endpackage

// File: rtl/agp_cmd_decode.sv
// Command decoder: classifies a presented request and computes the byte
// enables it will carry toward memory. Purely combinational.
// Assumes to_hub is meaningful for reads and writes only.
module agp_cmd_decode
    import agp_disp_pkg::*;
#(
    parameter int BW = BEW
) (
    input  logic [3:0]    cmd,
    input  logic          to_hub,
    input  logic [BW-1:0] be_in,
    output logic          ok,
    output logic          hi,
    output kind_e         kind,
    output logic [BW-1:0] be_out
);

    dec_t d;

    // Decode class and kind, then pick the effective byte enables
    always_comb begin
        d    = decode_cmd(cmd, to_hub);
        ok   = d.ok;
        hi   = d.hi;
        kind = d.kind;
        case (d.kind)
            KD_RD:   be_out = '1;
            KD_WR:   be_out = to_hub ? '0 : be_in;
            default: be_out = '0;
        endcase
    end

endmodule

// File: rtl/agp_req_fifo.sv
// Request queue: a plain synchronous FIFO with first-word fall-through.
// Assumes the user never pushes when full nor pops when empty.
// Push and pop in the same cycle are allowed.
module agp_req_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Next position with wrap for any depth
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entry storage, not reset
    always_ff @(posedge clk) begin
        if (push) store[wp] <= din;
    end

    assign dout  = store[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/agp_out_ctr.sv
// Outstanding-read counter for one priority class.
// Assumes dec never arrives while the count is zero (guarded anyway).
module agp_out_ctr #(
    parameter int MAXC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic zero,
    output logic full
);

    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Count reads issued minus read beats returned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= (cnt != '0) ? cnt - 1'b1 : cnt;
                default: cnt <= cnt;
            endcase
        end
    end

    assign zero = (cnt == '0);
    assign full = (cnt == CW'(MAXC));

endmodule

// File: rtl/agp_issue_arb.sv
// Issue stage: picks which queue head to serve and how.
// High priority wins unless a memory request is being held for mem_ready.
// Reads stall at the outstanding limit of their class. Local completions
// wait for an idle class and an idle return path. Fences retire at once.
module agp_issue_arb
    import agp_disp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] q_empty,
    input  kind_e      kind_lo,
    input  kind_e      kind_hi,
    input  logic [1:0] c_zero,
    input  logic [1:0] c_full,
    input  logic       mem_ready,
    input  logic       mem_rvalid,
    output logic       mem_valid,
    output logic [1:0] q_pop,
    output logic       sel_hi,
    output logic       loc_fire,
    output logic       rd_go
);

    logic  held, held_hi;
    logic  any, pop_now;
    kind_e kind;

    // Select a head and decide what it does this cycle
    always_comb begin
        sel_hi    = held ? held_hi : !q_empty[1];
        any       = !q_empty[sel_hi];
        kind      = sel_hi ? kind_hi : kind_lo;
        mem_valid = 1'b0;
        loc_fire  = 1'b0;
        pop_now   = 1'b0;
        if (any) begin
            case (kind)
                KD_RD:    mem_valid = !c_full[sel_hi];
                KD_WR:    mem_valid = 1'b1;
                KD_LOC:   loc_fire  = c_zero[sel_hi] && !mem_rvalid;
                KD_FENCE: pop_now   = 1'b1;
                default:  pop_now   = 1'b0;
            endcase
        end
        if ((mem_valid && mem_ready) || loc_fire)
            pop_now = 1'b1;
        q_pop = pop_now ? (sel_hi ? 2'b10 : 2'b01) : 2'b00;
        rd_go = mem_valid && mem_ready && (kind == KD_RD);
    end

    // Remember a stalled memory request so its class stays selected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= 1'b0;
            held_hi <= 1'b0;
        end else begin
            held    <= mem_valid && !mem_ready;
            held_hi <= sel_hi;
        end
    end

endmodule

// File: rtl/agp_req_dispatch.sv
// Request dispatcher top. Decodes a request and queues it per priority
// class. Serves queue heads toward the DRAM-side port, or completes them
// locally with FILL_PAT, and forwards returned read data as completions.
// Assumes one read-data beat per memory read, returned in issue order
// within each class, and never for a class with nothing outstanding.
module agp_req_dispatch
    import agp_disp_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          LW       = 6,
    parameter int          DEPTH    = 8,
    parameter int          OUT_MAX  = 15,
    parameter logic [63:0] FILL_PAT = 64'hD1CE_0BAD_F00D_5EED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_cmd,
    input  logic          req_to_hub,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [7:0]    req_be,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic          mem_hipri,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic [7:0]    mem_be,
    input  logic          mem_rvalid,
    input  logic          mem_rhipri,
    input  logic [63:0]   mem_rdata,
    output logic          cpl_valid,
    output logic          cpl_hipri,
    output logic [63:0]   cpl_data
);

    localparam int NCLS = 2;

    typedef struct packed {
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [7:0]    be;
    } ent_t;

    localparam int EW = $bits(ent_t);

    logic          d_ok, d_hi, accept;
    kind_e         d_kind;
    logic [7:0]    d_be;
    ent_t          new_ent;
    logic [EW-1:0] new_raw;

    logic [NCLS-1:0] q_push, q_pop, q_empty, q_full;
    logic [NCLS-1:0] c_inc, c_dec, c_zero, c_full;
    logic [EW-1:0]   q_dout [NCLS];
    ent_t            q_head [NCLS];
    ent_t            sel_ent;
    logic            sel_hi, loc_fire, rd_go;

    agp_cmd_decode #(.BW(8)) u_dec (
        .cmd    (req_cmd),
        .to_hub (req_to_hub),
        .be_in  (req_be),
        .ok     (d_ok),
        .hi     (d_hi),
        .kind   (d_kind),
        .be_out (d_be)
    );

    // Admission: reserved codes always pass, others need room in their queue
    always_comb begin
        req_ready    = !d_ok || !q_full[d_hi];
        accept       = req_valid && req_ready && d_ok;
        new_ent.kind = d_kind;
        new_ent.addr = req_addr;
        new_ent.len  = req_len;
        new_ent.be   = d_be;
        new_raw      = new_ent;
    end

    // One queue and one outstanding-read counter per priority class
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign q_push[c] = accept && (d_hi == 1'(c));

        agp_req_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[c]),
            .din   (new_raw),
            .pop   (q_pop[c]),
            .dout  (q_dout[c]),
            .empty (q_empty[c]),
            .full  (q_full[c])
        );

        assign q_head[c] = ent_t'(q_dout[c]);
        assign c_inc[c]  = rd_go && (sel_hi == 1'(c));
        assign c_dec[c]  = mem_rvalid && (mem_rhipri == 1'(c));

        agp_out_ctr #(.MAXC(OUT_MAX)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (c_inc[c]),
            .dec   (c_dec[c]),
            .zero  (c_zero[c]),
            .full  (c_full[c])
        );
    end

    agp_issue_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .kind_lo    (q_head[0].kind),
        .kind_hi    (q_head[1].kind),
        .c_zero     (c_zero),
        .c_full     (c_full),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_valid  (mem_valid),
        .q_pop      (q_pop),
        .sel_hi     (sel_hi),
        .loc_fire   (loc_fire),
        .rd_go      (rd_go)
    );

    // Drive the memory request fields from the selected head
    always_comb begin
        sel_ent   = sel_hi ? q_head[1] : q_head[0];
        mem_write = (sel_ent.kind == KD_WR);
        mem_hipri = sel_hi;
        mem_addr  = sel_ent.addr;
        mem_len   = sel_ent.len;
        mem_be    = sel_ent.be;
    end

    // Completion register: returned read data first, else a local fill beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_hipri <= 1'b0;
            cpl_data  <= '0;
        end else if (mem_rvalid) begin
            cpl_valid <= 1'b1;
            cpl_hipri <= mem_rhipri;
            cpl_data  <= mem_rdata;
        end else if (loc_fire) begin
            cpl_valid <= 1'b1;
            cpl_hipri <= sel_hi;
            cpl_data  <= FILL_PAT;
        end else begin
            cpl_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/agp_disp_chk.sv
// Assertion checker for the dispatcher, bound to every instance of the top.
module agp_disp_chk #(
    parameter int AW = 32,
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [3:0]    req_cmd,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic          mem_hipri,
    input logic [AW-1:0] mem_addr,
    input logic [LW-1:0] mem_len,
    input logic [7:0]    mem_be,
    input logic          mem_rvalid,
    input logic          mem_rhipri,
    input logic [63:0]   mem_rdata,
    input logic          cpl_valid,
    input logic          cpl_hipri,
    input logic [63:0]   cpl_data
);

    logic rsv;

    // Flag the reserved command codes
    always_comb begin
        case (req_cmd)
            4'h2, 4'h3, 4'h6, 4'h7, 4'hB, 4'hD, 4'hE, 4'hF: rsv = 1'b1;
            default:                                        rsv = 1'b0;
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_valid && !cpl_valid));

    // R3
    reserved_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsv) |-> req_ready);

    // R2
    read_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |-> (mem_be == 8'hFF));

    // R10
    rdata_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> (cpl_valid && cpl_data == $past(mem_rdata)
                        && cpl_hipri == $past(mem_rhipri)));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)
            && $stable(mem_hipri) && $stable(mem_addr)
            && $stable(mem_len) && $stable(mem_be)));

endmodule

bind agp_req_dispatch agp_disp_chk #(.AW(AW), .LW(LW)) u_disp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cmd    (req_cmd),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_hipri  (mem_hipri),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len),
    .mem_be     (mem_be),
    .mem_rvalid (mem_rvalid),
    .mem_rhipri (mem_rhipri),
    .mem_rdata  (mem_rdata),
    .cpl_valid  (cpl_valid),
    .cpl_hipri  (cpl_hipri),
    .cpl_data   (cpl_data)
);

// File: tb/agp_req_dispatch_test.sv
// Bench: behavioural reference model (queues) compared on every clock.
module agp_req_dispatch_test;

    localparam int          AW      = 16;
    localparam int          LW      = 4;
    localparam int          DEPTH   = 4;
    localparam int          OUT_MAX = 3;
    localparam logic [63:0] FILL    = 64'hD1CE_0BAD_F00D_5EED;
    localparam int          NS      = 20;
    localparam logic [4:0]  SCRIPT [NS] = '{
        5'h00, 5'h01, 5'h04, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0C, 5'h00, 5'h02,
        5'h03, 5'h06, 5'h07, 5'h0B, 5'h0D, 5'h0E, 5'h0F, 5'h10, 5'h14, 5'h19};

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_to_hub = 1'b0;
    logic [3:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [7:0]    req_be = '0;
    logic          mem_ready = 1'b0, mem_rvalid = 1'b0, mem_rhipri = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          req_ready, mem_valid, mem_write, mem_hipri;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_len;
    logic [7:0]    mem_be;
    logic          cpl_valid, cpl_hipri;
    logic [63:0]   cpl_data;

    always #10 clk = ~clk;

    agp_req_dispatch #(.AW(AW), .LW(LW), .DEPTH(DEPTH), .OUT_MAX(OUT_MAX),
                       .FILL_PAT(FILL)) uut (.*);

    // Model state
    typedef struct {
        int            kind;   // 0 read, 1 write, 2 local, 3 fence
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [7:0]    be;
    } ment_t;

    ment_t         lo_q[$], hi_q[$], h;
    logic [AW-1:0] out_lo[$], out_hi[$];
    bit            m_held, m_held_hi;
    bit            e_ready, e_mv, s_hi, s_any, s_pop, s_loc;
    bit            e_cv, e_ch;
    logic [63:0]   e_cd;
    bit            d_ok, d_hi;
    int            d_kind;

    int  n_chk = 0, n_err = 0, mode = 0, sidx = 0;
    bit  pend = 0, done = 0;
    int  x_memrd = 0, x_wr = 0, x_hubwr = 0, x_flush = 0, x_hubrd = 0, x_fence = 0, x_rsv = 0;
    int  o_rd = 0, o_wr = 0, o_be0 = 0, o_cpl = 0, o_fill = 0, o_stall = 0, o_pri = 0, o_rdylow = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Command map taken from the requirements
    task automatic mdec(input logic [3:0] c, input logic hub);
        d_ok = 1; d_hi = 0; d_kind = 0;
        case (c)
            4'h0, 4'h8: d_kind = 0;
            4'h1, 4'h9: begin d_hi = 1; d_kind = 0; end
            4'h4:       d_kind = 1;
            4'h5:       begin d_hi = 1; d_kind = 1; end
            4'hA:       d_kind = 2;
            4'hC:       d_kind = 3;
            default:    d_ok = 0;
        endcase
        if (d_ok && hub && d_kind == 0) d_kind = 2;
    endtask

    // Expected combinational outputs from model state and current inputs
    task automatic m_eval();
        int cnt;
        mdec(req_cmd, req_to_hub);
        e_ready = !d_ok || (d_hi ? hi_q.size() < DEPTH : lo_q.size() < DEPTH);
        s_hi  = m_held ? m_held_hi : (hi_q.size() > 0);
        s_any = s_hi ? (hi_q.size() > 0) : (lo_q.size() > 0);
        cnt   = s_hi ? out_hi.size() : out_lo.size();
        e_mv = 0; s_pop = 0; s_loc = 0;
        if (s_any) begin
            h = s_hi ? hi_q[0] : lo_q[0];
            case (h.kind)
                0: e_mv = (cnt < OUT_MAX);
                1: e_mv = 1;
                2: s_loc = (cnt == 0) && !mem_rvalid;
                default: s_pop = 1;
            endcase
            if ((e_mv && mem_ready) || s_loc) s_pop = 1;
        end
    endtask

    // Advance model state at the clock edge
    task automatic m_step();
        ment_t n;
        if (mem_rvalid) begin
            e_cv = 1; e_cd = mem_rdata; e_ch = mem_rhipri;
            if (mem_rhipri) void'(out_hi.pop_front()); else void'(out_lo.pop_front());
        end else if (s_loc) begin
            e_cv = 1; e_cd = FILL; e_ch = s_hi;
        end else e_cv = 0;
        if (s_pop) begin
            if (h.kind == 0) begin
                if (s_hi) out_hi.push_back(h.addr); else out_lo.push_back(h.addr);
            end
            if (s_hi) void'(hi_q.pop_front()); else void'(lo_q.pop_front());
        end
        m_held = e_mv && !mem_ready; m_held_hi = s_hi;
        if (req_valid && e_ready) begin
            pend = 0;
            if (!d_ok) x_rsv++;
            else begin
                n.kind = d_kind; n.addr = req_addr; n.len = req_len;
                n.be = (d_kind == 0) ? 8'hFF : (d_kind == 1 ? (req_to_hub ? 8'h00 : req_be) : 8'h00);
                if (d_hi) hi_q.push_back(n); else lo_q.push_back(n);
                case (d_kind)
                    0: x_memrd++;
                    1: begin x_wr++; if (req_to_hub) x_hubwr++; end
                    2: if (req_cmd == 4'hA) x_flush++; else x_hubrd++;
                    default: x_fence++;
                endcase
            end
        end
    endtask

    // Drive inputs for one cycle according to the phase
    task automatic gen();
        logic [3:0] pick [6] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h1, 4'h5};
        bit both;
        if (!pend) begin
            case (mode)
                0: if (sidx < NS) begin
                       req_cmd = SCRIPT[sidx][3:0]; req_to_hub = SCRIPT[sidx][4]; sidx++; pend = 1;
                   end
                1: if ($urandom % 2 == 0) begin
                       req_cmd = pick[$urandom % 6]; req_to_hub = 0; pend = 1;
                   end
                2: if ($urandom % 3 != 0) begin
                       req_cmd = 4'($urandom); req_to_hub = ($urandom % 4 == 0); pend = 1;
                   end
                default: ;
            endcase
            if (pend) begin
                req_addr = AW'($urandom); req_len = LW'($urandom); req_be = 8'($urandom) | 8'h01;
            end
        end
        req_valid = pend;
        mem_ready = (mode == 1) ? 1'b0 : (mode == 2) ? ($urandom % 10 < 7) : 1'b1;
        mem_rvalid = 0;
        if ((out_lo.size() > 0 || out_hi.size() > 0) && mode != 1 && (mode != 2 || $urandom % 2 == 0)) begin
            both = out_lo.size() > 0 && out_hi.size() > 0;
            mem_rvalid = 1;
            mem_rhipri = both ? 1'($urandom) : (out_hi.size() > 0);
            mem_rdata = {16'h600D, 15'h0, mem_rhipri, 16'h0,
                         mem_rhipri ? out_hi[0] : out_lo[0]};
        end
    endtask

    // Compare every output and gather port-level event counts
    task automatic compare();
        chk(req_ready === e_ready, "R9 req_ready", 64'(req_ready), 64'(e_ready));
        chk(mem_valid === e_mv, "R8 mem_valid", 64'(mem_valid), 64'(e_mv));
        if (e_mv && mem_valid)
            chk({mem_write, mem_hipri, mem_be, mem_len, mem_addr} ===
                {(h.kind == 1), s_hi, h.be, h.len, h.addr},
                "R2/R6/R11 mem request fields",
                64'({mem_write, mem_hipri, mem_be, mem_len, mem_addr}),
                64'({(h.kind == 1), s_hi, h.be, h.len, h.addr}));
        chk(cpl_valid === e_cv, "R10 cpl_valid", 64'(cpl_valid), 64'(e_cv));
        if (e_cv && cpl_valid) begin
            chk(cpl_data === e_cd, "R10 cpl_data", cpl_data, e_cd);
            chk(cpl_hipri === e_ch, "R10 cpl_hipri", 64'(cpl_hipri), 64'(e_ch));
        end
        if (mem_valid && mem_ready) begin
            if (mem_write) o_wr++; else o_rd++;
            if (mem_write && mem_be == 8'h00) o_be0++;
            if (mem_hipri && lo_q.size() > 0) o_pri++;
        end
        if (mem_valid && !mem_ready) o_stall++;
        if (req_valid && !req_ready) o_rdylow++;
        if (cpl_valid) begin
            o_cpl++;
            if (cpl_data == FILL) o_fill++;
        end
    endtask

    task automatic run(input int m, input int n);
        mode = m;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gen();
            #1;
            m_eval();
            compare();
            @(posedge clk);
            m_step();
        end
    endtask

    initial begin
        e_cv = 0; m_held = 0; m_held_hi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(mem_valid === 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 64'd0);
        chk(cpl_valid === 1'b0, "R1 cpl_valid after reset", 64'(cpl_valid), 64'd0);
        chk(req_ready === 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
        @(posedge clk);
        run(0, 60);
        run(1, 40);
        run(2, 3000);
        run(3, 100);
        // R2 reads and writes reach memory
        chk(o_rd == x_memrd, "R2 memory read count", 64'(o_rd), 64'(x_memrd));
        chk(o_wr == x_wr, "R2 memory write count", 64'(o_wr), 64'(x_wr));
        // R3 reserved codes return nothing; R7 fences return nothing
        chk(o_cpl == x_memrd + x_flush + x_hubrd, "R3 completion count", 64'(o_cpl),
            64'(x_memrd + x_flush + x_hubrd));
        chk(x_rsv > 0, "R3 reserved codes taken", 64'(x_rsv), 64'd1);
        // R4 and R5 filler completions
        chk(o_fill == x_flush + x_hubrd, "R4/R5 filler beats", 64'(o_fill), 64'(x_flush + x_hubrd));
        // R6 hub writes carry no byte enables
        chk(o_be0 == x_hubwr, "R6 zero-enable writes", 64'(o_be0), 64'(x_hubwr));
        // R7 fences issue no memory request
        chk(x_fence > 0 && o_rd + o_wr == x_memrd + x_wr, "R7 fence issues nothing",
            64'(o_rd + o_wr), 64'(x_memrd + x_wr));
        // R8 high priority overtook a waiting normal head
        chk(o_pri > 0, "R8 high before normal", 64'(o_pri), 64'd1);
        // R9 full queue refused a request
        chk(o_rdylow > 0, "R9 ready dropped", 64'(o_rdylow), 64'd1);
        // R11 stalled requests were seen
        chk(o_stall > 0, "R11 stalled request", 64'(o_stall), 64'd1);
        // R10 everything drained
        chk(lo_q.size() + hi_q.size() + out_lo.size() + out_hi.size() == 0, "R10 drained",
            64'(lo_q.size() + hi_q.size()), 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog expired act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule